// File: doc/BRIEF.md
# Write Enable and Block Protect Unit

This unit guards every write into a small serial nonvolatile memory. It keeps the write-enable latch and a two-bit block-protect code, builds the status byte that a status read returns, and for each byte that the command decoder is about to store it answers whether the store may happen. The serial front end and the storage array sit outside it; they hand it one-cycle strobes for the enable, disable, status-write and end-of-write events, the level of the active-low write-protect pin, and the target address of each array byte.

A write only proceeds when three independent conditions agree: the latch is set, the protect pin is high, and (for array bytes) the address lies outside the range selected by the protect code. The latch drops by itself when a write operation finishes, so every write operation needs a fresh enable. The protect code survives everything except a power-on reset, where it is loaded from a parameter in place of nonvolatile storage.

Top module: `wr_guard`

## Requirements
- R1: After reset the status byte reads `BP_INIT` in bits 3:2 and zeros elsewhere; with the default `BP_INIT` of 0 it reads 8'h00.
- R2: An enable strobe (`set_we`) makes status bit 1 read 1 from the next cycle; a disable strobe (`clr_we`) makes it read 0 from the next cycle.
- R3: An end-of-write strobe (`op_done`) clears the latch from the next cycle, so a later array or status write is refused until a new enable strobe.
- R4: Status bits 7:4 and bit 0 always read 0; bit 3 and bit 2 carry the upper and lower protect bits, bit 1 carries the latch.
- R5: A granted status write copies only bits 3:2 of `sr_wdata` into the protect code; bits 7:4, 1 and 0 of the data have no effect, and the protect code holds in every cycle without a granted status write.
- R6: The protect code selects the blocked addresses: 00 none, 01 addresses 0x180 to 0x1FF, 10 addresses 0x100 to 0x1FF, 11 every address.
- R7: While `wp_n` is 0 neither grant is given, and a refused status write leaves the protect code unchanged.
- R8: `arr_grant` is 1 in the same cycle as `arr_req` exactly when the latch is set, `wp_n` is 1 and `arr_addr` is outside the blocked range.
- R9: `sr_grant` is 1 in the same cycle as `sr_req` exactly when the latch is set and `wp_n` is 1.
- R10: The protect pin is judged only in the cycle of each byte request, so a low pulse between two bytes of one operation does not refuse the byte requested while the pin is high again, and a low level at a request refuses that byte only.
- R11: When an enable strobe coincides with a disable or end-of-write strobe, the latch reads 0 afterwards.
- R12: Without a request neither grant is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| set_we | input | 1 | Enable-latch set strobe |
| clr_we | input | 1 | Enable-latch clear strobe |
| op_done | input | 1 | End of a write operation |
| wp_n | input | 1 | Write-protect pin level, active low |
| arr_req | input | 1 | An array byte is ready to be stored |
| arr_addr | input | ADDR_W | Address of that array byte |
| sr_req | input | 1 | A status byte is ready to be stored |
| sr_wdata | input | 8 | Status byte received |
| status | output | 8 | Readable status byte |
| arr_grant | output | 1 | Array byte may be stored |
| sr_grant | output | 1 | Status byte may be stored |

## Verification
The zone decode is driven by a table pairing each protect code with addresses on both sides of its boundary (0x0FF/0x100, 0x17F/0x180) and at the array ends, which separates a correct boundary from one off by a quarter or a half. Latch tests alternate enable, disable and end-of-write strobes, including coincident ones, and follow multi-byte operations to show that grants persist inside an operation and stop after it. Status writes with all-ones data and with the pin low show which bits may change and when the pin blocks, and pin pulses between bytes show that only the level at each request counts.

// File: rtl/wr_guard_pkg.sv
// Shared constants and types for the write guard.
// Assumes an 8-bit status byte with the protect code at bits 3:2.
package wr_guard_pkg;
    localparam int STAT_W   = 8;
    localparam int WEL_POS  = 1;
    localparam int BP_LO    = 2;
    localparam int BP_HI    = 3;

    typedef enum logic [1:0] {
        BP_NONE = 2'b00,
        BP_QTR  = 2'b01,
        BP_HALF = 2'b10,
        BP_ALL  = 2'b11
    } bp_code_e;
endpackage

// File: rtl/wr_guard_wel.sv
// Write-enable latch. Clear requests win over a set in the same cycle.
// Assumes one-cycle strobes from the command decoder.
module wr_guard_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_we,
    input  logic clr_we,
    input  logic op_done,
    output logic wel
);
    logic clr_any;

    // Any clearing event this cycle.
    always_comb clr_any = clr_we | op_done;

    // Latch update with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (clr_any) wel <= 1'b0;
        else if (set_we)  wel <= 1'b1;
    end
endmodule

// File: rtl/wr_guard_bp.sv
// Block-protect code register. Loaded from BP_INIT at power-on reset only,
// updated solely by a granted status write.
module wr_guard_bp
    import wr_guard_pkg::*;
#(
    parameter logic [1:0] BP_INIT = 2'b00
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic [1:0] new_code,
    output bp_code_e code
);
    // Hold or take the new protect code.
    always_ff @(posedge clk) begin
        if (!rst_n)    code <= bp_code_e'(BP_INIT);
        else if (load) code <= bp_code_e'(new_code);
    end
endmodule

// File: rtl/wr_guard_zone.sv
// Decides whether an address falls in the range blocked by the protect code.
// Assumes ADDR_W >= 2; ranges are the top quarter, top half or whole space.
module wr_guard_zone
    import wr_guard_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  bp_code_e           code,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit
);
    localparam int MSB = ADDR_W - 1;

    logic top_half;
    logic top_qtr;

    // Region flags from the upper address bits.
    always_comb begin
        top_half = addr[MSB];
        top_qtr  = addr[MSB] & addr[MSB-1];
    end

    // Select blocked region by code.
    always_comb begin
        unique case (code)
            BP_NONE: hit = 1'b0;
            BP_QTR:  hit = top_qtr;
            BP_HALF: hit = top_half;
            BP_ALL:  hit = 1'b1;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wr_guard.sv
// Write guard top: holds the enable latch and protect code, forms the
// status byte and grants array and status writes byte by byte.
// Assumes the pin level is judged in the cycle of each byte request.
module wr_guard
    import wr_guard_pkg::*;
#(
    parameter int         ADDR_W  = 9,
    parameter logic [1:0] BP_INIT = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic              op_done,
    input  logic              wp_n,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              sr_req,
    input  logic [STAT_W-1:0] sr_wdata,
    output logic [STAT_W-1:0] status,
    output logic              arr_grant,
    output logic              sr_grant
);
    logic     wel;
    bp_code_e code;
    logic     zone_hit;
    logic     may_write;
    logic     unused_sr_bits;

    wr_guard_wel u_wel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (set_we),
        .clr_we  (clr_we),
        .op_done (op_done),
        .wel     (wel)
    );

    wr_guard_bp #(.BP_INIT(BP_INIT)) u_bp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sr_grant),
        .new_code (sr_wdata[BP_HI:BP_LO]),
        .code     (code)
    );

    wr_guard_zone #(.ADDR_W(ADDR_W)) u_zone (
        .code (code),
        .addr (arr_addr),
        .hit  (zone_hit)
    );

    // Bits of the status data that are never stored.
    assign unused_sr_bits = ^{sr_wdata[STAT_W-1:BP_HI+1], sr_wdata[WEL_POS:0]};

    // Common permission: latch set and pin released.
    always_comb may_write = wel & wp_n;

    // Per-byte grants.
    always_comb begin
        sr_grant  = sr_req  & may_write;
        arr_grant = arr_req & may_write & ~zone_hit;
    end

    // Assemble the readable status byte.
    always_comb begin
        status              = '0;
        status[BP_HI:BP_LO] = code;
        status[WEL_POS]     = wel;
    end
endmodule

// File: rtl/wr_guard_chk.sv
// Property checker for wr_guard, attached by bind.
module wr_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_we,
    input logic       clr_we,
    input logic       op_done,
    input logic       wp_n,
    input logic       arr_req,
    input logic       sr_req,
    input logic [7:0] status,
    input logic       arr_grant,
    input logic       sr_grant
);
    p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we && !op_done) |=> status[1]);

    p_wel_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we || op_done) |=> !status[1]);

    p_fixed_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:4] == 4'h0) && !status[0]);

    p_bp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_grant |=> $stable(status[3:2]));

    p_all_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == 2'b11) |-> !arr_grant);

    p_pin_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |-> (!arr_grant && !sr_grant));

    p_arr_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant |-> status[1]);

    p_sr_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_req && status[1] && wp_n) |-> sr_grant);

    p_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_req |-> !arr_grant) and (!sr_req |-> !sr_grant));
endmodule

bind wr_guard wr_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_we    (set_we),
    .clr_we    (clr_we),
    .op_done   (op_done),
    .wp_n      (wp_n),
    .arr_req   (arr_req),
    .sr_req    (sr_req),
    .status    (status),
    .arr_grant (arr_grant),
    .sr_grant  (sr_grant)
);

// File: tb/tb_wr_guard.sv
module tb_wr_guard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       set_we, clr_we, op_done, wp_n;
    logic       arr_req, sr_req;
    logic [8:0] arr_addr;
    logic [7:0] sr_wdata;
    logic [7:0] status;
    logic       arr_grant, sr_grant;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wr_guard dut (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
        .op_done(op_done), .wp_n(wp_n), .arr_req(arr_req), .arr_addr(arr_addr),
        .sr_req(sr_req), .sr_wdata(sr_wdata), .status(status),
        .arr_grant(arr_grant), .sr_grant(sr_grant)
    );

    // Zone table: {protect code, address, expected grant}
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {2'b00, 9'h000, 1'b1}, {2'b00, 9'h1FF, 1'b1},
        {2'b01, 9'h17F, 1'b1}, {2'b01, 9'h180, 1'b0}, {2'b01, 9'h1FF, 1'b0},
        {2'b10, 9'h0FF, 1'b1}, {2'b10, 9'h100, 1'b0}, {2'b10, 9'h1FF, 1'b0},
        {2'b11, 9'h000, 1'b0}, {2'b11, 9'h1FF, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wren();
        set_we = 1'b1; tick(); set_we = 1'b0;
    endtask

    task automatic wrdi();
        clr_we = 1'b1; tick(); clr_we = 1'b0;
    endtask

    task automatic done_op();
        op_done = 1'b1; tick(); op_done = 1'b0;
    endtask

    // Status write: returns grant seen in the request cycle.
    task automatic wrsr(input logic [7:0] d, output logic g);
        sr_req = 1'b1; sr_wdata = d; #1; g = sr_grant;
        tick(); sr_req = 1'b0;
    endtask

    task automatic arr_byte(input logic [8:0] a, output logic g);
        arr_req = 1'b1; arr_addr = a; #1; g = arr_grant;
        tick(); arr_req = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic g;
        rst_n = 1'b0; set_we = 0; clr_we = 0; op_done = 0; wp_n = 1;
        arr_req = 0; sr_req = 0; arr_addr = '0; sr_wdata = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset status", status, 8'h00);

        // Zone table walk (R6, R8)
        for (int i = 0; i < NV; i++) begin
            wren();
            wrsr({4'h0, VEC[i][11:10], 2'b00}, g);
            done_op();
            wren();
            arr_byte(VEC[i][9:1], g);
            chk($sformatf("R6 R8 zone vec %0d", i), g, VEC[i][0]);
            done_op();
        end

        // Back to no protection
        wren(); wrsr(8'h00, g); done_op();
        chk("R5 code cleared", status, 8'h00);

        // R2 set and clear
        wren();
        chk("R2 set", status, 8'h02);
        wrdi();
        chk("R2 clear", status, 8'h00);

        // R11 coincident set and clear
        set_we = 1; clr_we = 1; tick(); set_we = 0; clr_we = 0;
        chk("R11 clear wins over set", status[1], 1'b0);
        set_we = 1; op_done = 1; tick(); set_we = 0; op_done = 0;
        chk("R11 end-of-write wins over set", status[1], 1'b0);

        // R9 status write refused without latch
        wrsr(8'h0C, g);
        chk("R9 no latch no grant", g, 1'b0);
        chk("R9 code unchanged", status, 8'h00);

        // R3 multi-byte operation then auto-clear
        wren();
        arr_byte(9'h1FE, g); chk("R3 byte 1 granted", g, 1'b1);
        arr_byte(9'h1FF, g); chk("R3 byte 2 granted", g, 1'b1);
        chk("R3 latch held in op", status[1], 1'b1);
        done_op();
        chk("R3 latch cleared", status[1], 1'b0);
        arr_byte(9'h000, g); chk("R3 next write refused", g, 1'b0);

        // R12 no request, latch set
        wren();
        #1;
        chk("R12 no array grant", arr_grant, 1'b0);
        chk("R12 no status grant", sr_grant, 1'b0);

        // R10 pin pulse between bytes
        arr_byte(9'h010, g); chk("R10 first byte", g, 1'b1);
        wp_n = 0; tick(); wp_n = 1;
        arr_byte(9'h011, g); chk("R10 pin high at request", g, 1'b1);
        wp_n = 0;
        arr_byte(9'h012, g); chk("R10 pin low at request", g, 1'b0);
        wp_n = 1;
        arr_byte(9'h013, g); chk("R10 pin released again", g, 1'b1);
        done_op();

        // R7 pin low blocks status write
        wren();
        wp_n = 0;
        wrsr(8'hFF, g);
        chk("R7 status write blocked", g, 1'b0);
        chk("R7 code and latch kept", status, 8'h02);
        wp_n = 1;

        // R5 R4 all-ones status write
        wrsr(8'hFF, g);
        chk("R9 status grant", g, 1'b1);
        chk("R4 R5 status layout", status, 8'h0E);
        done_op();
        chk("R5 only protect bits stored", status, 8'h0C);

        // R1 power-on reset reloads code
        rst_n = 0; tick(); rst_n = 1; tick();
        chk("R1 reset reloads code", status, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule